// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block derives a symmetric baud clock from the system clock. A sixteen-bit time constant, written into the block one byte at a time, sets the reload value of a down counter. Each time the counter expires, it reloads and toggles a divide-by-two flip-flop. The baud clock therefore runs at clk / (2 x (TC + 2)). For a reference clock f, a wanted rate B and a clock-mode factor M, software chooses TC = f / (2 x B x M) - 2.

A second stage counts rising edges of the baud clock and emits a one-cycle bit strobe every M of them, with M selected as 1, 16, 32 or 64. Software writes the two time-constant bytes and the mode while the generator is disabled, then raises the enable. A new time constant written while the generator runs takes effect at the next reload. It never truncates the half period in progress.

Top module: `baud_gen`

## Requirements
- R1: After reset, baud_clk and bit_strobe are low and both time-constant bytes are zero, so enabling without any write gives a half period of 2 cycles.
- R2: A write with wr_en high stores wr_data into the low byte (TC bits 7:0) when wr_sel is 0 and into the high byte (TC bits 15:8) when wr_sel is 1, one clock later.
- R3: Once enable is high, baud_clk first rises on the (TC+2)-th rising clock edge after the first edge that sees enable high, and it toggles every TC+2 edges after that, so its frequency is clk / (2 x (TC + 2)).
- R4: baud_clk has a 50 % duty cycle: its high and low phases both last TC+2 cycles.
- R5: A time-constant write made while the generator runs does not change the half period in progress; the new value governs from the next reload on.
- R6: While enable is low, baud_clk is low from the next edge on and the counter keeps reloading the current time constant, so a re-enable restarts with a full first half period.
- R7: mode_sel selects the strobe divisor: 2'b00 = 1, 2'b01 = 16, 2'b10 = 32, 2'b11 = 64. bit_strobe is high for exactly one cycle, in the same cycle that baud_clk rises, on every divisor-th rising edge counted from enable.
- R8: In mode 2'b00, bit_strobe accompanies every rising edge of baud_clk.
- R9: With TC = 0, baud_clk runs at clk / 4, the fastest rate, and never changes on two consecutive edges.
- R10: Dropping enable clears the rising-edge count, so after re-enable the first strobe comes on the divisor-th rising edge again.
- R11: With a 9.8304 MHz reference, mode 16 and 76800 baud, the formula gives TC = 2, and the bit strobe then recurs every 128 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Time-constant byte write strobe |
| wr_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Byte to write |
| mode_sel | input | 2 | Strobe divisor select (1, 16, 32, 64) |
| enable | input | 1 | Run the generator; low holds it reloaded with output low |
| baud_clk | output | 1 | Symmetric divided clock |
| bit_strobe | output | 1 | One-cycle pulse every divisor-th baud_clk rising edge |

## Verification
The hardest case to reach from the ports is a time-constant write that lands inside a running half period. The write must land after the counter has loaded the old value and before that value expires. The bench enables the generator with a short constant, counts edges from enable, and issues the low-byte write two edges in. It then checks that the first toggle still follows the old constant and the later ones follow the new one. A disable in mid-run, followed by a count out to the sixteenth rising edge, shows that the strobe divider restarts rather than resuming.

// File: rtl/baud_pkg.sv
// Package: shared widths, the strobe-mode encoding and its divisor lookup.
// Assumes: byte-wide register writes and a two-byte time constant.
package baud_pkg;

    localparam int BYTE_W  = 8;
    localparam int TC_W    = 2 * BYTE_W;
    localparam int DIV_MAX = 64;
    localparam int DIV_W   = $clog2(DIV_MAX);

    typedef enum logic [1:0] {
        MODE_X1  = 2'b00,
        MODE_X16 = 2'b01,
        MODE_X32 = 2'b10,
        MODE_X64 = 2'b11
    } strobe_mode_e;

    // Returns the last count value (divisor - 1) for a strobe mode.
    function automatic logic [DIV_W-1:0] mode_last(strobe_mode_e m);
        logic [DIV_W-1:0] r;
        case (m)
            MODE_X1:  r = DIV_W'(0);
            MODE_X16: r = DIV_W'(15);
            MODE_X32: r = DIV_W'(31);
            default:  r = DIV_W'(63);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/baud_tc_regs.sv
// Module: holds the time constant as two separately written bytes.
// Assumes: one byte write per cycle; the reset value of both bytes is zero.
module baud_tc_regs #(
    parameter int BYTE_W = 8,
    localparam int TC_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [TC_W-1:0]   tc
);

    logic [BYTE_W-1:0] byte_q [2];

    // One register per byte lane, selected by wr_sel.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        // Capture the written byte when this lane is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q[g] <= '0;
            end else if (wr_en && (wr_sel == 1'(g))) begin
                byte_q[g] <= wr_data;
            end
        end
        assign tc[g*BYTE_W +: BYTE_W] = byte_q[g];
    end

endmodule

// File: rtl/baud_down_counter.sv
// Module: down counter that runs from TC to zero, spends one extra cycle
// before reloading, and flags the reload cycle. The half period is TC+2.
// Assumes: tc is sampled only while disabled or at a reload.
module baud_down_counter #(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [TC_W-1:0] tc,
    output logic            reload
);

    logic [TC_W-1:0] cnt_q;
    logic            pend_q;

    // Count down; after zero, wait one cycle and then load the constant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (!enable) begin
            cnt_q  <= tc;
            pend_q <= 1'b0;
        end else if (pend_q) begin
            cnt_q  <= tc;
            pend_q <= 1'b0;
        end else if (cnt_q == '0) begin
            pend_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The reload happens at the edge that ends the pending cycle.
    always_comb reload = enable && pend_q;

endmodule

// File: rtl/baud_half_toggle.sv
// Module: divide-by-two flip-flop that produces the symmetric baud clock.
// Assumes: reload pulses are at least two cycles apart.
module baud_half_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic reload,
    output logic baud_clk,
    output logic rise
);

    logic out_q;

    // Toggle on each reload; hold low while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (!enable) begin
            out_q <= 1'b0;
        end else if (reload) begin
            out_q <= ~out_q;
        end
    end

    // A reload while the output is low turns into a rising edge.
    always_comb rise = reload && !out_q;
    assign baud_clk = out_q;

endmodule

// File: rtl/baud_mode_divider.sv
// Module: counts rising edges of the baud clock and strobes on every
// divisor-th one, in the cycle the baud clock goes high.
// Assumes: mode is stable while enabled.
module baud_mode_divider
    import baud_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         rise,
    input  strobe_mode_e mode,
    output logic         strobe
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;
    logic             strobe_q;

    // Last count value for the selected divisor.
    always_comb last = mode_last(mode);

    // Count rising edges; wrap and strobe at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (rise) begin
                if (cnt_q >= last) begin
                    cnt_q    <= '0;
                    strobe_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign strobe = strobe_q;

endmodule

// File: rtl/baud_gen.sv
// Module: top of the programmable baud rate generator. It chains the
// time-constant registers, the down counter, the divide-by-two stage and
// the strobe-mode divider.
// Assumes: mode and constant are programmed before enable is raised.
module baud_gen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        mode_sel,
    input  logic              enable,
    output logic              baud_clk,
    output logic              bit_strobe
);

    logic [TC_W-1:0] tc_value;
    logic            reload;
    logic            rise;
    strobe_mode_e    mode;

    // Decode the mode pins into the shared enumeration.
    always_comb mode = strobe_mode_e'(mode_sel);

    baud_tc_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .tc      (tc_value)
    );

    baud_down_counter #(.TC_W(TC_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .tc     (tc_value),
        .reload (reload)
    );

    baud_half_toggle u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .reload   (reload),
        .baud_clk (baud_clk),
        .rise     (rise)
    );

    baud_mode_divider u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .rise   (rise),
        .mode   (mode),
        .strobe (bit_strobe)
    );

endmodule

// File: rtl/baud_gen_chk.sv
// Module: assertion checker bound to baud_gen. It watches the ports and
// the stored time constant.
module baud_gen_chk
    import baud_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic [1:0]        mode_sel,
    input logic              enable,
    input logic              baud_clk,
    input logic              bit_strobe,
    input logic [TC_W-1:0]   tc_value
);

    AST_LOW_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (tc_value[BYTE_W-1:0] == $past(wr_data))); // R2

    AST_HIGH_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (tc_value[TC_W-1:BYTE_W] == $past(wr_data))); // R2

    AST_LOW_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !baud_clk); // R6

    AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> $rose(baud_clk)); // R7

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe); // R7

    AST_MODE1_EVERY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(baud_clk) && ($past(mode_sel) == 2'b00)) |-> bit_strobe); // R8

    AST_MIN_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(baud_clk) |=> (baud_clk || !$past(enable))); // R9

endmodule

bind baud_gen baud_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .mode_sel   (mode_sel),
    .enable     (enable),
    .baud_clk   (baud_clk),
    .bit_strobe (bit_strobe),
    .tc_value   (tc_value)
);

// File: tb/baud_gen_tb.sv
module baud_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] mode_sel = 2'b00;
    logic       enable = 1'b0;
    logic       baud_clk;
    logic       bit_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    baud_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .mode_sel   (mode_sel),
        .enable     (enable),
        .baud_clk   (baud_clk),
        .bit_strobe (bit_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int divisor(input logic [1:0] m);
        case (m)
            2'b00:   return 1;
            2'b01:   return 16;
            2'b10:   return 32;
            default: return 64;
        endcase
    endfunction

    // Model: level of the baud clock e edges after enable.
    function automatic int exp_clk(input int e, input int tc);
        return ((e / (tc + 2)) % 2);
    endfunction

    // Model: strobe e edges after enable.
    function automatic int exp_strobe(input int e, input int tc, input int n);
        int q;
        q = e / (tc + 2);
        if (e % (tc + 2) != 0) return 0;
        if (q % 2 != 1) return 0;
        return (((q + 1) / 2) % n == 0) ? 1 : 0;
    endfunction

    task automatic write_byte(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Program the constant and mode while disabled, then run and compare.
    task automatic run_sweep(input int tc, input logic [1:0] m, input int cycles,
                             input string req_clk, input string req_stb);
        @(negedge clk);
        enable = 1'b0;
        write_byte(1'b0, tc[7:0]);
        write_byte(1'b1, tc[15:8]);
        mode_sel = m;
        @(negedge clk);
        enable = 1'b1;
        for (int e = 1; e <= cycles; e++) begin
            @(negedge clk);
            check(req_clk, int'(baud_clk), exp_clk(e, tc), "baud_clk");
            check(req_stb, int'(bit_strobe), exp_strobe(e, tc, divisor(m)), "bit_strobe");
        end
        enable = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check("R1", int'(baud_clk), 0, "baud_clk after reset");
        check("R1", int'(bit_strobe), 0, "bit_strobe after reset");

        // R1: zero time constant out of reset gives a half period of 2.
        enable = 1'b1;
        for (int e = 1; e <= 12; e++) begin
            @(negedge clk);
            check("R1", int'(baud_clk), exp_clk(e, 0), "baud_clk zero TC");
            check("R8", int'(bit_strobe), exp_strobe(e, 0, 1), "bit_strobe zero TC");
        end
        enable = 1'b0;

        // R3 R4 R7 R8 R9: sweep small constants over all four modes.
        for (int tc = 0; tc <= 5; tc++) begin
            for (int m = 0; m < 4; m++) begin
                run_sweep(tc, 2'(m), 2 * (tc + 2) * divisor(2'(m)) * 2 + 3,
                          (tc == 0) ? "R9" : "R4", (m == 0) ? "R8" : "R7");
            end
        end

        // R2: high byte lane, TC = 0x0102.
        run_sweep(16'h0102, 2'b00, 2 * 260 * 2 + 3, "R2", "R8");

        // R11: 9.8304 MHz / (2 x 76800 x 16) - 2 = 2, strobe every 128 cycles.
        begin
            int tc_calc;
            tc_calc = 9830400 / (2 * 76800 * 16) - 2;
            check("R11", tc_calc, 2, "computed TC");
            run_sweep(tc_calc, 2'b01, 3 * 128 + 2, "R3", "R11");
        end

        // R5: write a new constant inside a running half period.
        @(negedge clk);
        write_byte(1'b1, 8'h00);
        write_byte(1'b0, 8'd3);
        mode_sel = 2'b00;
        @(negedge clk);
        enable = 1'b1;
        for (int e = 1; e <= 22; e++) begin
            @(negedge clk);
            if (e == 2) begin
                wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'd6;
            end else begin
                wr_en = 1'b0;
            end
            if (e == 4)  check("R5", int'(baud_clk), 0, "before old-TC toggle");
            if (e == 5)  check("R5", int'(baud_clk), 1, "old TC governs first half");
            if (e == 12) check("R5", int'(baud_clk), 1, "new TC half high");
            if (e == 13) check("R5", int'(baud_clk), 0, "new TC first fall");
            if (e == 20) check("R5", int'(baud_clk), 0, "new TC half low");
            if (e == 21) check("R5", int'(baud_clk), 1, "new TC second rise");
        end
        enable = 1'b0;

        // R6 R10: disable mid-run while high, then re-enable.
        @(negedge clk);
        write_byte(1'b0, 8'd2);
        mode_sel = 2'b01;
        @(negedge clk);
        enable = 1'b1;
        for (int e = 1; e <= 5; e++) @(negedge clk);
        check("R6", int'(baud_clk), 1, "high before disable");
        enable = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R6", int'(baud_clk), 0, "low while disabled");
            check("R6", int'(bit_strobe), 0, "no strobe while disabled");
        end
        enable = 1'b1;
        for (int e = 1; e <= 130; e++) begin
            @(negedge clk);
            check("R6", int'(baud_clk), exp_clk(e, 2), "restart after re-enable");
            check("R10", int'(bit_strobe), exp_strobe(e, 2, 16), "divider restart");
        end
        enable = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule